// File: doc/BRIEF.md
# Dual-Rank Refresh Scheduler with Temperature Doubling

This block produces refresh requests for a memory controller that serves two separately selected DRAM ranks. A down-counting interval timer fires once per refresh interval. Every time it fires, both ranks are owed one more refresh, because each rank has its own select and clock enable and must be refreshed on its own. Each rank keeps a saturating count of the refreshes it is still owed. The block offers one rank at a time to a downstream command arbiter through a valid/grant handshake.

The nominal interval is a parameter in clock cycles. At 250 MHz, 1950 cycles gives a 7.8 us spacing, which fits 8192 refreshes into a 64 ms retention window. When the hot input is high, the interval is halved (about 3.9 us), so the same count fits into 32 ms. The chosen interval is captured only when the timer reloads, so a temperature change never shortens or stretches a count that is already running. When both ranks owe refreshes, the offered rank alternates. A rank whose owed count reaches the cap raises its urgent flag so the arbiter can raise the priority of refresh.

Top module: `refresh_sched`

## Requirements
- R1: A synchronous active-high reset clears both owed counts, lowers `req_valid_o` and `urgent_o`, and restarts the timer. The first request appears on the NORM_CYC-th rising edge after reset is released, with `hot_i` low.
- R2: With `hot_i` low, the interval timer fires once every NORM_CYC clock cycles.
- R3: While `hot_i` is high, the interval is NORM_CYC/2 cycles. A change of `hot_i` applies only to the interval that begins at the next timer expiry, never to the one already running.
- R4: Each timer expiry adds one owed refresh to each rank. Each count saturates at MAX_OWED (8 by default), and further expiries are lost.
- R5: `urgent_o[r]` (bit 0 = rank 0, bit 1 = rank 1) is high exactly while rank r owes MAX_OWED refreshes.
- R6: `req_valid_o` is high while either rank owes at least one refresh. A rising edge with `grant_i` and `req_valid_o` both high removes one owed refresh from the rank shown on `req_rank_o` (0 = rank 0, 1 = rank 1).
- R7: When both ranks owe refreshes, the offered rank is the one not granted last. After reset, rank 0 is treated as first. When only one rank owes, that rank is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hot_i | input | 1 | High-temperature flag, selects the halved interval |
| grant_i | input | 1 | Arbiter accepts the offered refresh |
| req_valid_o | output | 1 | A refresh is owed to some rank |
| req_rank_o | output | 1 | Rank the offered refresh targets |
| urgent_o | output | 2 | Per-rank flag: owed count at its cap |

## Verification
The bench targets four corner cases.

- **Hot flag raised mid-interval.** The bench raises `hot_i` partway through an interval and lowers it again later. It checks that the first expiry after each change still lands on the old spacing. A design that reloads the period immediately would produce a request too early or too late.
- **Saturation.** Ten expiries pass without grants, then the bench drains both ranks. Exactly sixteen grants must empty the block. A counter that wraps or keeps counting past the cap would need a different number of grants, or would stall at zero.
- **Per-rank urgent flags.** After one grant, only rank 1 may still be urgent. This exposes flags that are shared between ranks or that lag the count.
- **Arbitration choice.** The scoreboard checks the offered rank on every grant. It covers strict alternation, the lone-owing-rank case, and the first choice after reset. A stuck or inverted choice shows up as a wrong rank.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int unsigned RANKS = 2;

    typedef enum logic {
        RANK_A = 1'b0,
        RANK_B = 1'b1
    } rank_e;

    typedef struct packed {
        logic  valid;
        rank_e rank;
    } rfs_offer_t;

    // Halved interval used while the hot flag is set; never below one cycle.
    function automatic int unsigned hot_interval(input int unsigned base);
        return (base / 2 < 1) ? 1 : base / 2;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer
    import rfs_pkg::*;
#(
    parameter int unsigned NORM_CYC = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic hot_i,
    output logic tick_o
);
    localparam int unsigned HOT_CYC = hot_interval(NORM_CYC);
    localparam int unsigned CW      = $clog2(NORM_CYC + 1);
    localparam logic [CW-1:0] NORM_V = CW'(NORM_CYC);
    localparam logic [CW-1:0] HOT_V  = CW'(HOT_CYC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period_q;
    logic [CW-1:0] period_sel;

    assign period_sel = hot_i ? HOT_V : NORM_V;
    assign tick_o     = (cnt_q == '0);

    // The period is sampled only at reload, so a mode change waits for expiry.
    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= period_sel;
            cnt_q    <= period_sel - 1'b1;
        end else if (tick_o) begin
            period_q <= period_sel;
            cnt_q    <= period_sel - 1'b1;
        end else begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q < period_q); // R2

    AST_MODE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(period_q)); // R3

    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (period_q == NORM_V) || (period_q == HOT_V)); // R3

endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr #(
    parameter int unsigned MAX_OWED = 8,
    parameter int unsigned W        = $clog2(MAX_OWED + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         dec_i,
    output logic [W-1:0] owed_o,
    output logic         urgent_o
);
    localparam logic [W-1:0] MAX_V = W'(MAX_OWED);

    logic [W-1:0] owed_q;
    logic [W-1:0] owed_nxt;

    // A tick and a grant in the same cycle cancel out.
    always_comb begin
        owed_nxt = owed_q;
        unique case ({tick_i, dec_i})
            2'b10:   if (owed_q != MAX_V) owed_nxt = owed_q + 1'b1;
            2'b01:   if (owed_q != '0)    owed_nxt = owed_q - 1'b1;
            default: owed_nxt = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owed_q <= '0;
        else     owed_q <= owed_nxt;
    end

    assign owed_o   = owed_q;
    assign urgent_o = (owed_q == MAX_V);

    AST_DEBT_CAP: assert property (@(posedge clk) disable iff (rst)
        owed_q <= MAX_V); // R4

    AST_TICK_ADDS: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !dec_i && owed_q < MAX_V) |=> owed_q == $past(owed_q) + 1'b1); // R4

    AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !tick_i && owed_q != '0) |=> owed_q == $past(owed_q) - 1'b1); // R6

endmodule

// File: rtl/rfs_rank_arb.sv
module rfs_rank_arb
    import rfs_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     owed0_i,
    input  logic [W-1:0]     owed1_i,
    input  logic             grant_i,
    output rfs_offer_t       offer_o,
    output logic [RANKS-1:0] dec_o
);
    rank_e last_q;
    logic  owe0;
    logic  owe1;

    assign owe0 = (owed0_i != '0);
    assign owe1 = (owed1_i != '0);

    always_comb begin
        offer_o.valid = owe0 | owe1;
        if (owe0 && owe1) offer_o.rank = rank_e'(~last_q);
        else if (owe1)    offer_o.rank = RANK_B;
        else              offer_o.rank = RANK_A;
    end

    generate
        for (genvar r = 0; r < RANKS; r++) begin : g_dec
            assign dec_o[r] = grant_i && offer_o.valid && (offer_o.rank == rank_e'(r));
        end
    endgenerate

    // Reset value makes rank 0 the first choice when both owe.
    always_ff @(posedge clk) begin
        if (rst)                            last_q <= RANK_B;
        else if (grant_i && offer_o.valid)  last_q <= offer_o.rank;
    end

    AST_OFFER_BACKED: assert property (@(posedge clk) disable iff (rst)
        offer_o.valid |-> ((offer_o.rank == RANK_A) ? owe0 : owe1)); // R6

    AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (grant_i && owed0_i > W'(1) && owed1_i > W'(1)) |=> offer_o.rank != $past(offer_o.rank)); // R7

    AST_ONE_DEC: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec_o)); // R6

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rfs_pkg::*;
#(
    parameter int unsigned NORM_CYC = 1950,
    parameter int unsigned MAX_OWED = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hot_i,
    input  logic       grant_i,
    output logic       req_valid_o,
    output logic       req_rank_o,
    output logic [1:0] urgent_o
);
    localparam int unsigned DW = $clog2(MAX_OWED + 1);

    logic             tick;
    logic [DW-1:0]    owed [RANKS];
    logic [RANKS-1:0] dec;
    rfs_offer_t       offer;

    rfs_interval_timer #(.NORM_CYC(NORM_CYC)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    generate
        for (genvar r = 0; r < RANKS; r++) begin : g_rank
            rfs_debt_ctr #(.MAX_OWED(MAX_OWED), .W(DW)) debt_i (
                .clk      (clk),
                .rst      (rst),
                .tick_i   (tick),
                .dec_i    (dec[r]),
                .owed_o   (owed[r]),
                .urgent_o (urgent_o[r])
            );
        end
    endgenerate

    rfs_rank_arb #(.W(DW)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .owed0_i (owed[0]),
        .owed1_i (owed[1]),
        .grant_i (grant_i),
        .offer_o (offer),
        .dec_o   (dec)
    );

    assign req_valid_o = offer.valid;
    assign req_rank_o  = offer.rank;

    AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (urgent_o != 2'b00) |-> req_valid_o); // R5

endmodule

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
    localparam int unsigned NORM = 40;
    localparam int unsigned MAXO = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hot_i = 1'b0;
    logic       grant_i = 1'b0;
    logic       req_valid_o;
    logic       req_rank_o;
    logic [1:0] urgent_o;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    refresh_sched #(.NORM_CYC(NORM), .MAX_OWED(MAXO)) dut_i (
        .clk(clk), .rst(rst), .hot_i(hot_i), .grant_i(grant_i),
        .req_valid_o(req_valid_o), .req_rank_o(req_rank_o), .urgent_o(urgent_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, ncyc, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        ncyc++;
        #1;
    endtask

    task automatic step_to(input int target);
        while (ncyc < target) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        ncyc = 0;
    endtask

    // Driver: announce the expected rank, then grant for one edge.
    task automatic grant_expect(input int rank);
        exp_q.push_back(rank);
        grant_i = 1'b1;
        step();
        grant_i = 1'b0;
    endtask

    // Monitor: compare the offered rank while a grant is pending.
    always @(negedge clk) begin
        if (grant_i && !rst) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected grant", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R6 valid at grant", int'(req_valid_o), 1);
                chk("R7 offered rank", int'(req_rank_o), e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state and first interval, R1 / R2
        do_reset();
        chk("R1 valid after reset", int'(req_valid_o), 0);
        chk("R1 urgent after reset", int'(urgent_o), 0);
        step_to(NORM - 1);
        chk("R2 no request before interval", int'(req_valid_o), 0);
        step_to(NORM);
        chk("R1 first request at interval", int'(req_valid_o), 1);
        step_to(8 * NORM - 1);
        chk("R5 not urgent at 7 owed", int'(urgent_o), 0);
        step_to(8 * NORM);
        chk("R5 urgent at cap", int'(urgent_o), 3);
        step_to(10 * NORM);
        chk("R4 still capped", int'(urgent_o), 3);
        // Drain: saturation must leave exactly 8 per rank
        grant_expect(0);
        chk("R5 urgent per rank", int'(urgent_o), 2);
        grant_expect(1);
        for (int i = 0; i < 7; i++) begin
            grant_expect(0);
            grant_expect(1);
        end
        chk("R4 drained after 16 grants", int'(req_valid_o), 0);
        chk("R5 urgent cleared", int'(urgent_o), 0);

        // Reset mid-operation, then temperature switching, R1 / R3
        step_to(ncyc + 25);
        do_reset();
        chk("R1 valid after mid reset", int'(req_valid_o), 0);
        step_to(10);
        hot_i = 1'b1;
        step_to(NORM / 2);
        chk("R3 running interval not cut", int'(req_valid_o), 0);
        step_to(NORM);
        chk("R3 expiry on old spacing", int'(req_valid_o), 1);
        grant_expect(0);
        grant_expect(1);
        step_to(NORM + NORM / 2 - 1);
        chk("R3 hot interval not early", int'(req_valid_o), 0);
        step_to(NORM + NORM / 2);
        chk("R3 hot interval length", int'(req_valid_o), 1);
        grant_expect(0);
        grant_expect(1);
        step_to(70);
        hot_i = 1'b0;
        step_to(2 * NORM - 1);
        chk("R3 hot spacing kept after clear", int'(req_valid_o), 0);
        step_to(2 * NORM);
        chk("R3 hot spacing kept after clear", int'(req_valid_o), 1);
        grant_expect(0);
        grant_expect(1);
        step_to(3 * NORM - 1);
        chk("R2 normal spacing restored", int'(req_valid_o), 0);
        step_to(3 * NORM);
        chk("R2 normal spacing restored", int'(req_valid_o), 1);

        // Lone owing rank, then alternation resumes, R7
        grant_expect(0);
        chk("R7 lone rank valid", int'(req_valid_o), 1);
        chk("R7 lone rank offered", int'(req_rank_o), 1);
        step_to(4 * NORM);
        grant_expect(1);
        grant_expect(0);
        grant_expect(1);
        chk("R6 empty after drain", int'(req_valid_o), 0);
        step();
        chk("R6 scoreboard empty", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule